// File: doc/BRIEF.md
# Single-Entry Delayed-Write Store Buffer

This block sits between the memory stage of an in-order pipeline and the write port of a set-associative data array. A store that reaches the memory stage only checks tags there. When the tag check hits, the block keeps the store's data, byte enables, word address and the way that hit in a single pending slot. The data array is not written in that cycle. The pending store is written into the array later, using the recorded way. This happens when the next store that hits takes over the slot, or in any free cycle with no memory-stage traffic. Splitting the store this way keeps the tag check and the array write out of the same cycle.

Loads probe the pending slot in the same cycle as their array read. A load whose word address matches the slot gets the buffered bytes merged over the array read data. Any tag miss, from a load or a store, first writes the pending slot into the array. Only then does the block raise its fill request to the external fill engine, so a buffered write can never land in a line the fill is about to replace. The pipeline keeps presenting a stalled operation until it is accepted.

Top module: `sbuf_top`

## Requirements
- R1: While the block is in reset and right after it, stall, wr_en, fill_req and ld_fwd are 0 and the slot is empty.
- R2: A store that hits the tags while the slot is empty is accepted without stall and without a data-array write in that cycle. Its word address (address without its low log2(DW/8) bits), data, byte enables and hit way are held in the slot.
- R3: A store that hits the tags while the slot is full and the write port is free writes the held entry in the same cycle. It drives wr_en=1, wr_index = held word address, wr_way, wr_data and wr_be from the slot. The new store then takes the slot, with no stall.
- R4: A load that hits the tags while the slot holds the same word address sets ld_fwd=1. Byte lane b of ld_data (bits 8b+7..8b) comes from the slot when held byte enable b is 1, and from ld_rdata otherwise. Low address bits inside the word are ignored for the match.
- R5: A load with no matching slot entry returns ld_rdata unchanged on ld_data, with ld_fwd=0.
- R6: A load tag miss while the slot is full stalls the pipeline and writes the slot into the array, with fill_req=0. Once the slot is empty the block raises fill_req with stall=1, and fill_addr carries the missing load address.
- R7: A store tag miss behaves the same way: it drains first, then raises fill_req with fill_addr = store address. The missing store is not captured.
- R8: When a store and a load that hits are both presented while the slot is full, the load is served (and forwarded if it matches). The store is stalled, and no array write happens in that cycle.
- R9: While arr_busy=1 the block never drives wr_en. An operation that needs a drain in that cycle is stalled instead.
- R10: With no store and no load presented and arr_busy=0, a full slot is written to the array. Afterwards the slot is empty.
- R11: Once the slot has been written out, a load to its former address is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store present in memory stage |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data word |
| st_be | input | DW/8 | Store byte enables |
| st_tag_hit | input | 1 | Tag check result for the store |
| st_way | input | WAYW | Way that hit for the store |
| ld_valid | input | 1 | Load present in memory stage |
| ld_addr | input | AW | Load byte address |
| ld_tag_hit | input | 1 | Tag check result for the load |
| ld_rdata | input | DW | Data-array read word for the load |
| ld_data | output | DW | Load result after forwarding merge |
| ld_fwd | output | 1 | Load was served from the slot |
| arr_busy | input | 1 | Data-array write port used by the fill engine |
| wr_en | output | 1 | Data-array write strobe |
| wr_index | output | AW-log2(DW/8) | Word address of the array write |
| wr_way | output | WAYW | Way of the array write |
| wr_data | output | DW | Array write data |
| wr_be | output | DW/8 | Array write byte enables |
| stall | output | 1 | Hold the memory stage this cycle |
| fill_req | output | 1 | Request a line fill from the fill engine |
| fill_addr | output | AW | Address of the missing access |

## Verification
The bench targets partial byte enables during forwarding. A merge that ignored enables would return stale array bytes or buffered garbage in the upper lanes. It also presents a store and a load in the same cycle: a design that drained anyway would write the array while the load's forwarding source vanished. Misses are sent against a full slot to catch fill_req raised before the drain, which would expose a replaced line to a late write. Idle drains and busy write ports are covered too, which exposes a slot left valid after it was written out, or a write issued while the port is taken.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Decision taken by the controller for one memory-stage cycle
  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,  // nothing happens to the slot
    ACT_CAPTURE = 3'd1,  // empty slot takes the store
    ACT_SWAP    = 3'd2,  // old entry written, new store captured
    ACT_DRAIN   = 3'd3,  // old entry written, slot emptied
    ACT_HOLD    = 3'd4   // slot kept, pipeline stalled
  } sbuf_act_e;

endpackage

// File: rtl/sbuf_entry.sv
module sbuf_entry #(
  parameter int IW   = 14,
  parameter int DW   = 32,
  parameter int WAYW = 2,
  localparam int NB  = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            clr_en,
  input  logic [IW-1:0]   in_idx,
  input  logic [DW-1:0]   in_data,
  input  logic [NB-1:0]   in_be,
  input  logic [WAYW-1:0] in_way,
  output logic            vld,
  output logic [IW-1:0]   idx,
  output logic [DW-1:0]   data,
  output logic [NB-1:0]   be,
  output logic [WAYW-1:0] way
);

  logic            vld_d;
  logic            pay_en;

  // valid bit: capture wins over clear in the same cycle
  always_comb begin
    vld_d = vld;
    if (cap_en) begin
      vld_d = 1'b1;
    end else if (clr_en) begin
      vld_d = 1'b0;
    end
  end

  assign pay_en = cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
    end else begin
      vld <= vld_d;
    end
  end

  // payload registers carry no reset, only an enable
  always_ff @(posedge clk) begin
    if (pay_en) begin
      idx  <= in_idx;
      data <= in_data;
      be   <= in_be;
      way  <= in_way;
    end
  end

endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
  parameter int IW  = 14,
  parameter int DW  = 32,
  localparam int NB = DW / 8
) (
  input  logic          ent_vld,
  input  logic [IW-1:0] ent_idx,
  input  logic [DW-1:0] ent_data,
  input  logic [NB-1:0] ent_be,
  input  logic          ld_valid,
  input  logic          ld_tag_hit,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_rdata,
  output logic [DW-1:0] ld_data,
  output logic          ld_fwd
);

  logic word_match;

  assign word_match = ent_vld && (ent_idx == ld_idx);
  assign ld_fwd     = ld_valid && ld_tag_hit && word_match;

  // per byte lane: buffered byte over array byte when enabled
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign ld_data[b*8 +: 8] = (ld_fwd && ent_be[b]) ? ent_data[b*8 +: 8]
                                                       : ld_rdata[b*8 +: 8];
  end

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl #(
  parameter bit EAGER_DRAIN = 1'b1
) (
  input  logic               ent_vld,
  input  logic               st_valid,
  input  logic               st_tag_hit,
  input  logic               ld_valid,
  input  logic               ld_tag_hit,
  input  logic               arr_busy,
  output sbuf_pkg::sbuf_act_e act,
  output logic               stall,
  output logic               fill_req,
  output logic               fill_from_ld
);
  import sbuf_pkg::*;

  logic idle_ok;
  logic ld_miss;
  logic st_miss;

  // variant: drain on free cycles, or only when a store displaces the entry
  if (EAGER_DRAIN) begin : g_eager
    assign idle_ok = 1'b1;
  end else begin : g_lazy
    assign idle_ok = 1'b0;
  end

  assign ld_miss = ld_valid && !ld_tag_hit;
  assign st_miss = st_valid && !st_tag_hit;

  always_comb begin
    act          = ACT_IDLE;
    stall        = 1'b0;
    fill_req     = 1'b0;
    fill_from_ld = 1'b0;
    if (ld_miss) begin
      // load miss has top priority: empty the slot before any fill
      stall        = 1'b1;
      fill_from_ld = 1'b1;
      if (ent_vld) begin
        act = arr_busy ? ACT_HOLD : ACT_DRAIN;
      end else begin
        fill_req = 1'b1;
      end
    end else if (st_valid && ld_valid && ent_vld) begin
      // load lookup first; the store waits, drain deferred
      act   = ACT_HOLD;
      stall = 1'b1;
    end else if (st_miss) begin
      stall = 1'b1;
      if (ent_vld) begin
        act = arr_busy ? ACT_HOLD : ACT_DRAIN;
      end else begin
        fill_req = 1'b1;
      end
    end else if (st_valid) begin
      if (!ent_vld) begin
        act = ACT_CAPTURE;
      end else if (arr_busy) begin
        act   = ACT_HOLD;
        stall = 1'b1;
      end else begin
        act = ACT_SWAP;
      end
    end else if (!ld_valid && ent_vld && !arr_busy && idle_ok) begin
      act = ACT_DRAIN;
    end
  end

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top #(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int WAYS        = 4,
  parameter bit EAGER_DRAIN = 1'b1,
  localparam int NB         = DW / 8,
  localparam int OFFW       = $clog2(NB),
  localparam int IW         = AW - OFFW,
  localparam int WAYW       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [NB-1:0]   st_be,
  input  logic            st_tag_hit,
  input  logic [WAYW-1:0] st_way,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic            ld_tag_hit,
  input  logic [DW-1:0]   ld_rdata,
  output logic [DW-1:0]   ld_data,
  output logic            ld_fwd,
  input  logic            arr_busy,
  output logic            wr_en,
  output logic [IW-1:0]   wr_index,
  output logic [WAYW-1:0] wr_way,
  output logic [DW-1:0]   wr_data,
  output logic [NB-1:0]   wr_be,
  output logic            stall,
  output logic            fill_req,
  output logic [AW-1:0]   fill_addr
);
  import sbuf_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sbuf_act_e       act;
  logic            fill_from_ld;
  logic            ent_vld;
  logic [IW-1:0]   ent_idx;
  logic [DW-1:0]   ent_data;
  logic [NB-1:0]   ent_be;
  logic [WAYW-1:0] ent_way;
  logic            cap_en;
  logic            clr_en;

  sbuf_ctrl #(.EAGER_DRAIN(EAGER_DRAIN)) ctrl_i (
    .ent_vld     (ent_vld),
    .st_valid    (st_valid),
    .st_tag_hit  (st_tag_hit),
    .ld_valid    (ld_valid),
    .ld_tag_hit  (ld_tag_hit),
    .arr_busy    (arr_busy),
    .act         (act),
    .stall       (stall),
    .fill_req    (fill_req),
    .fill_from_ld(fill_from_ld)
  );

  assign cap_en = (act == ACT_CAPTURE) || (act == ACT_SWAP);
  assign clr_en = (act == ACT_DRAIN);
  assign wr_en  = (act == ACT_SWAP) || (act == ACT_DRAIN);

  sbuf_entry #(.IW(IW), .DW(DW), .WAYW(WAYW)) entry_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap_en),
    .clr_en (clr_en),
    .in_idx (st_addr[AW-1:OFFW]),
    .in_data(st_data),
    .in_be  (st_be),
    .in_way (st_way),
    .vld    (ent_vld),
    .idx    (ent_idx),
    .data   (ent_data),
    .be     (ent_be),
    .way    (ent_way)
  );

  assign wr_index  = ent_idx;
  assign wr_way    = ent_way;
  assign wr_data   = ent_data;
  assign wr_be     = ent_be;
  assign fill_addr = fill_from_ld ? ld_addr : st_addr;

  sbuf_fwd #(.IW(IW), .DW(DW)) fwd_i (
    .ent_vld   (ent_vld),
    .ent_idx   (ent_idx),
    .ent_data  (ent_data),
    .ent_be    (ent_be),
    .ld_valid  (ld_valid),
    .ld_tag_hit(ld_tag_hit),
    .ld_idx    (ld_addr[AW-1:OFFW]),
    .ld_rdata  (ld_rdata),
    .ld_data   (ld_data),
    .ld_fwd    (ld_fwd)
  );

endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_tag_hit,
  input logic          ld_valid,
  input logic          ld_tag_hit,
  input logic [DW-1:0] ld_rdata,
  input logic [DW-1:0] ld_data,
  input logic          ld_fwd,
  input logic          arr_busy,
  input logic          wr_en,
  input logic          stall,
  input logic          fill_req,
  input logic          ent_vld
);

  // R9
  busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_busy |-> !wr_en);

  // R6
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (!ent_vld && !wr_en && stall));

  // R8
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && ld_valid && ld_tag_hit && ent_vld) |-> (stall && !wr_en));

  // R2
  capture_fills_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_tag_hit && !stall) |=> ent_vld);

  // R10
  drain_empties_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(st_valid && st_tag_hit && !stall)) |=> !ent_vld);

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_fwd) |-> (ld_data == ld_rdata));

  // R4
  fwd_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd |-> (ld_valid && ld_tag_hit && ent_vld));

endmodule

bind sbuf_top sbuf_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_tag_hit(st_tag_hit),
  .ld_valid  (ld_valid),
  .ld_tag_hit(ld_tag_hit),
  .ld_rdata  (ld_rdata),
  .ld_data   (ld_data),
  .ld_fwd    (ld_fwd),
  .arr_busy  (arr_busy),
  .wr_en     (wr_en),
  .stall     (stall),
  .fill_req  (fill_req),
  .ent_vld   (ent_vld)
);

// File: tb/sbuf_top_tb_top.sv
module sbuf_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        st_valid;
  logic [15:0] st_addr;
  logic [31:0] st_data;
  logic [3:0]  st_be;
  logic        st_tag_hit;
  logic [1:0]  st_way;
  logic        ld_valid;
  logic [15:0] ld_addr;
  logic        ld_tag_hit;
  logic [31:0] ld_rdata;
  logic [31:0] ld_data;
  logic        ld_fwd;
  logic        arr_busy;
  logic        wr_en;
  logic [13:0] wr_index;
  logic [1:0]  wr_way;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        stall;
  logic        fill_req;
  logic [15:0] fill_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  sbuf_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_tag_hit(st_tag_hit), .st_way(st_way),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag_hit(ld_tag_hit),
    .ld_rdata(ld_rdata), .ld_data(ld_data), .ld_fwd(ld_fwd),
    .arr_busy(arr_busy), .wr_en(wr_en), .wr_index(wr_index), .wr_way(wr_way),
    .wr_data(wr_data), .wr_be(wr_be), .stall(stall), .fill_req(fill_req),
    .fill_addr(fill_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one memory-stage cycle: drive at negedge, outputs settle, sample later
  task automatic cyc(input logic sv, input logic sh, input logic [15:0] sa,
                     input logic [31:0] sd, input logic [3:0] sbe,
                     input logic [1:0] sw, input logic lv, input logic lh,
                     input logic [15:0] la, input logic [31:0] lrd,
                     input logic busy);
    @(negedge clk);
    st_valid = sv; st_tag_hit = sh; st_addr = sa; st_data = sd;
    st_be = sbe; st_way = sw;
    ld_valid = lv; ld_tag_hit = lh; ld_addr = la; ld_rdata = lrd;
    arr_busy = busy;
    #2;
  endtask

  task automatic t_reset();
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 0, 0, 16'h0, 32'h0, 0);
    check("R1", "stall", stall, 0);
    check("R1", "wr_en", wr_en, 0);
    check("R1", "fill_req", fill_req, 0);
    check("R1", "ld_fwd", ld_fwd, 0);
  endtask

  task automatic t_capture_and_forward();
    cyc(1, 1, 16'h0104, 32'hAABBCCDD, 4'hF, 2'd2, 0, 0, 16'h0, 32'h0, 0);
    check("R2", "wr_en", wr_en, 0);
    check("R2", "stall", stall, 0);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 1, 16'h0106, 32'h11111111, 0);
    check("R4", "ld_fwd", ld_fwd, 1);
    check("R4", "ld_data", ld_data, 32'hAABBCCDD);
  endtask

  task automatic t_swap_and_merge();
    cyc(1, 1, 16'h0200, 32'h12345678, 4'h3, 2'd1, 0, 0, 16'h0, 32'h0, 0);
    check("R3", "wr_en", wr_en, 1);
    check("R3", "wr_index", wr_index, 14'h041);
    check("R3", "wr_way", wr_way, 2);
    check("R3", "wr_data", wr_data, 32'hAABBCCDD);
    check("R3", "wr_be", wr_be, 4'hF);
    check("R3", "stall", stall, 0);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 1, 16'h0201, 32'hFFFFFFFF, 0);
    check("R4", "merged ld_data", ld_data, 32'hFFFF5678);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 1, 16'h0300, 32'hCAFEF00D, 0);
    check("R5", "ld_fwd", ld_fwd, 0);
    check("R5", "ld_data", ld_data, 32'hCAFEF00D);
  endtask

  task automatic t_same_cycle();
    cyc(1, 1, 16'h0400, 32'h0A0B0C0D, 4'hF, 2'd3, 1, 1, 16'h0200, 32'h0, 0);
    check("R8", "stall", stall, 1);
    check("R8", "wr_en", wr_en, 0);
    check("R8", "ld_fwd", ld_fwd, 1);
    check("R8", "ld_data", ld_data, 32'h00005678);
    cyc(1, 1, 16'h0400, 32'h0A0B0C0D, 4'hF, 2'd3, 0, 0, 16'h0, 32'h0, 0);
    check("R8", "retry wr_en", wr_en, 1);
    check("R8", "retry wr_index", wr_index, 14'h080);
    check("R8", "retry wr_way", wr_way, 1);
    check("R8", "retry wr_be", wr_be, 4'h3);
    check("R8", "retry stall", stall, 0);
  endtask

  task automatic t_busy_port();
    cyc(1, 1, 16'h0408, 32'h55667788, 4'hF, 2'd0, 0, 0, 16'h0, 32'h0, 1);
    check("R9", "stall", stall, 1);
    check("R9", "wr_en", wr_en, 0);
    cyc(1, 1, 16'h0408, 32'h55667788, 4'hF, 2'd0, 0, 0, 16'h0, 32'h0, 0);
    check("R9", "wr_en", wr_en, 1);
    check("R9", "wr_data", wr_data, 32'h0A0B0C0D);
    check("R9", "wr_index", wr_index, 14'h100);
    check("R9", "stall", stall, 0);
  endtask

  task automatic t_load_miss();
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 0, 16'h0500, 32'h0, 0);
    check("R6", "stall", stall, 1);
    check("R6", "drain wr_en", wr_en, 1);
    check("R6", "drain wr_index", wr_index, 14'h102);
    check("R6", "fill_req early", fill_req, 0);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 0, 16'h0500, 32'h0, 0);
    check("R6", "fill_req", fill_req, 1);
    check("R6", "fill_addr", fill_addr, 16'h0500);
    check("R6", "wr_en", wr_en, 0);
    check("R6", "stall", stall, 1);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 1, 16'h0408, 32'h0, 0);
    check("R11", "ld_fwd after drain", ld_fwd, 0);
  endtask

  task automatic t_store_miss();
    cyc(1, 1, 16'h0600, 32'h99999999, 4'hF, 2'd1, 0, 0, 16'h0, 32'h0, 0);
    check("R2", "wr_en", wr_en, 0);
    cyc(1, 0, 16'h0700, 32'h77777777, 4'hF, 2'd0, 0, 0, 16'h0, 32'h0, 0);
    check("R7", "stall", stall, 1);
    check("R7", "drain wr_en", wr_en, 1);
    check("R7", "drain wr_index", wr_index, 14'h180);
    check("R7", "fill_req early", fill_req, 0);
    cyc(1, 0, 16'h0700, 32'h77777777, 4'hF, 2'd0, 0, 0, 16'h0, 32'h0, 0);
    check("R7", "fill_req", fill_req, 1);
    check("R7", "fill_addr", fill_addr, 16'h0700);
    check("R7", "wr_en", wr_en, 0);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 1, 16'h0700, 32'h13579BDF, 0);
    check("R7", "no capture ld_fwd", ld_fwd, 0);
    check("R7", "no capture ld_data", ld_data, 32'h13579BDF);
  endtask

  task automatic t_idle_drain();
    cyc(1, 1, 16'h0800, 32'h2468ACE0, 4'hF, 2'd2, 0, 0, 16'h0, 32'h0, 0);
    check("R2", "stall", stall, 0);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 0, 0, 16'h0, 32'h0, 1);
    check("R10", "busy idle wr_en", wr_en, 0);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 0, 0, 16'h0, 32'h0, 0);
    check("R10", "idle wr_en", wr_en, 1);
    check("R10", "idle wr_index", wr_index, 14'h200);
    check("R10", "idle wr_data", wr_data, 32'h2468ACE0);
    check("R10", "idle wr_way", wr_way, 2);
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 1, 1, 16'h0800, 32'h0F0F0F0F, 0);
    check("R11", "ld_fwd after idle drain", ld_fwd, 0);
    check("R11", "ld_data", ld_data, 32'h0F0F0F0F);
  endtask

  initial begin
    rst_n = 1'b0;
    st_valid = 0; st_tag_hit = 0; st_addr = '0; st_data = '0; st_be = '0;
    st_way = '0; ld_valid = 0; ld_tag_hit = 0; ld_addr = '0; ld_rdata = '0;
    arr_busy = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "stall in reset", stall, 0);
    check("R1", "wr_en in reset", wr_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_capture_and_forward();
    t_swap_and_merge();
    t_same_cycle();
    t_busy_port();
    t_load_miss();
    t_store_miss();
    t_idle_drain();
    cyc(0, 0, 16'h0, 32'h0, 4'h0, 2'd0, 0, 0, 16'h0, 32'h0, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule